// File: doc/BRIEF.md
# Oversampled One-Bit Colour Dither

This block drives a display connector that has only one digital line per colour. It takes a stream of RGB pixels with 6-bit components, one pixel per pixel strobe. A fast clock runs at a whole multiple of the pixel rate, and the block toggles each colour line inside every pixel period. Over the pixel period, each line is high for a number of fast slots that tracks the component's intensity. The monitor's limited video bandwidth averages these slots, so each channel shows SLOTS+1 intensity levels instead of two. With the default of 8 slots per pixel (a fast clock near 200 MHz and a pixel clock near 25 MHz), that gives nine levels per channel.

Each 6-bit component is converted to a slot count with rounding. The high slots are spread evenly across the pixel period rather than bunched at its start, which keeps the energy of each pixel centred. A mode input turns the dither off. The block then drives each line from the component's most significant bit for the whole pixel, which gives the plain eight-colour palette. A blanking input forces all three lines low. Sync generation and the fast clock come from outside the block. The pixel strobe is a one-cycle pulse in the fast clock domain.

Top module: `oneBitDither`

## Requirements
- R1: While rstN is low, and after reset until the first pixel strobe, outR, outG and outB are all 0.
- R2: With ditherOn high, a component value v gives exactly n = round(v*SLOTS/63) high slots in its pixel (round half up). v=0 gives 0 high slots and v=63 gives all SLOTS slots high.
- R3: Within a pixel of slot count n, slot k (k = 0..SLOTS-1) is high exactly when floor((k+1)*n/SLOTS) > floor(k*n/SLOTS). This spreads the high slots evenly.
- R4: A pixel and the mode are captured on the clock edge at which pixStrobe is 1. Slot 0 is driven after the next edge, and slot k after the (k+1)-th edge. A strobe that arrives before all slots are out restarts at slot 0 with the new pixel.
- R5: If SLOTS edges pass after a strobe with no new strobe, all outputs go to 0 and stay 0 until the next strobe.
- R6: If blank is 1 at a clock edge, all three outputs are 0 after that edge, whatever the slot.
- R7: With ditherOn low at the strobe, each output holds the most significant bit (bit 5) of its component for every slot of that pixel.
- R8: The three channels are independent. Channel R is driven from pixR, channel G from pixG and channel B from pixB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modulation clock, a whole multiple of the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| pixStrobe | input | 1 | One-cycle pulse that marks a new pixel |
| pixR | input | 6 | Red component, sampled at the strobe |
| pixG | input | 6 | Green component, sampled at the strobe |
| pixB | input | 6 | Blue component, sampled at the strobe |
| blank | input | 1 | Forces all outputs low while high |
| ditherOn | input | 1 | 1 = multi-level dither, 0 = one bit per channel from the MSB |
| outR | output | 1 | Red colour line |
| outG | output | 1 | Green colour line |
| outB | output | 1 | Blue colour line |

## Verification
The bench counts high slots per pixel at the rounding boundaries (1, 4, 31, 32, 59, 63). A design that truncates instead of rounding, or that saturates short of full on, shows a count one off.

It checks every slot against the spreading rule, which catches output that is bunched at the start of the pixel or shifted by one edge. Early strobes must restart at slot 0, so a design that runs the old pixel to completion misses.

Late strobes must go dark after the last slot, so a design that replays the last pixel shows stray highs. Blanking in mid-pixel, mode changes, and distinct values per channel expose a design that ignores blank, latches the mode at the wrong time, or crosses channels.

// File: rtl/ditherPkg.sv
package ditherPkg;

  typedef struct packed {
    logic load;   // capture a new pixel this edge
    logic emit;   // a slot of the current pixel is due this edge
  } ditherCtl_t;

  // Rounded slot count for a component value: (v*slots)/maxValue, half up.
  function automatic int slotLevel(int value, int maxValue, int slots);
    return (value * 2 * slots + maxValue) / (2 * maxValue);
  endfunction

endpackage

// File: rtl/ditherCtrl.sv
module ditherCtrl
  import ditherPkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixStrobe,
  output ditherCtl_t ctl
);

  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(SLOTS);

  logic [CNT_W-1:0] slotCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= IDLE;
    end else if (pixStrobe) begin
      slotCnt <= '0;
    end else if (slotCnt != IDLE) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load = pixStrobe;
    ctl.emit = (slotCnt != IDLE);
  end

endmodule

// File: rtl/ditherPath.sv
module ditherPath
  import ditherPkg::*;
#(
  parameter int COMP_W   = 6,
  parameter int SLOTS    = 8,
  parameter int CHANNELS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ditherCtl_t                 ctl,
  input  logic [CHANNELS*COMP_W-1:0] pixIn,
  input  logic                       ditherOn,
  input  logic                       blank,
  output logic [CHANNELS-1:0]        dOut
);

  localparam int ACC_W = $clog2(SLOTS);
  localparam int LVL_W = ACC_W + 1;
  localparam int MAXV  = (1 << COMP_W) - 1;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gChan
    logic [COMP_W-1:0] comp;
    logic [LVL_W-1:0]  lvlNew;
    logic [LVL_W-1:0]  lvlReg;
    logic [ACC_W-1:0]  accReg;
    logic [LVL_W-1:0]  sum;
    logic              outBit;

    assign comp = pixIn[ch*COMP_W +: COMP_W];

    always_comb begin
      if (ditherOn) begin
        lvlNew = LVL_W'(slotLevel(int'(comp), MAXV, SLOTS));
      end else begin
        lvlNew = comp[COMP_W-1] ? LVL_W'(SLOTS) : '0;
      end
    end

    // Carry out of the accumulator marks a high slot.
    assign sum = {1'b0, accReg} + lvlReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvlReg <= '0;
        accReg <= '0;
        outBit <= 1'b0;
      end else begin
        outBit <= ctl.emit & ~blank & sum[ACC_W];
        if (ctl.load) begin
          lvlReg <= lvlNew;
          accReg <= '0;
        end else if (ctl.emit) begin
          accReg <= sum[ACC_W-1:0];
        end
      end
    end

    assign dOut[ch] = outBit;
  end

endmodule

// File: rtl/oneBitDither.sv
module oneBitDither
  import ditherPkg::*;
#(
  parameter int COMP_W = 6,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixStrobe,
  input  logic [COMP_W-1:0] pixR,
  input  logic [COMP_W-1:0] pixG,
  input  logic [COMP_W-1:0] pixB,
  input  logic              blank,
  input  logic              ditherOn,
  output logic              outR,
  output logic              outG,
  output logic              outB
);

  localparam int CHANNELS = 3;

  ditherCtl_t          ctl;
  logic [CHANNELS-1:0] dOut;

  ditherCtrl #(.SLOTS(SLOTS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pixStrobe(pixStrobe),
    .ctl      (ctl)
  );

  ditherPath #(.COMP_W(COMP_W), .SLOTS(SLOTS), .CHANNELS(CHANNELS)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .pixIn   ({pixB, pixG, pixR}),
    .ditherOn(ditherOn),
    .blank   (blank),
    .dOut    (dOut)
  );

  assign outR = dOut[0];
  assign outG = dOut[1];
  assign outB = dOut[2];

endmodule

// File: rtl/ditherChecker.sv
module ditherChecker #(
  parameter int COMP_W = 6,
  parameter int SLOTS  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixStrobe,
  input logic [COMP_W-1:0] pixR,
  input logic [COMP_W-1:0] pixG,
  input logic [COMP_W-1:0] pixB,
  input logic              blank,
  input logic              ditherOn,
  input logic              outR,
  input logic              outG,
  input logic              outB
);

  localparam int CW = $clog2(SLOTS + 1);

  logic [CW-1:0] gap;
  logic          seenEdge = 1'b0;

  always_ff @(posedge clk) seenEdge <= 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= CW'(SLOTS);
    else if (pixStrobe) gap <= '0;
    else if (gap != CW'(SLOTS)) gap <= gap + 1'b1;
  end

  always @(negedge clk) begin
    if (seenEdge && !rstN) begin
      assert_reset_low_R1: assert (!outR && !outG && !outB)
        else $error("outputs high during reset");
    end
  end

  assert_black_dark_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pixStrobe && pixR == '0) |=> ##1 !outR);

  assert_full_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pixStrobe && ditherOn && (&pixG)) ##1 !blank |=> outG);

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gap == CW'(SLOTS)) |=> (!outR && !outG && !outB));

  assert_blank_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    blank |=> (!outR && !outG && !outB));

  assert_msb_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pixStrobe && !ditherOn && !pixB[COMP_W-1]) |=> ##1 !outB);

endmodule

bind oneBitDither ditherChecker #(.COMP_W(COMP_W), .SLOTS(SLOTS)) chk_i (
  .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .pixR(pixR), .pixG(pixG),
  .pixB(pixB), .blank(blank), .ditherOn(ditherOn), .outR(outR), .outG(outG),
  .outB(outB)
);

// File: tb/oneBitDither_tb.sv
`timescale 1ns/1ps
module oneBitDither_tb_top;

  localparam int SL = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixStrobe = 1'b0;
  logic [5:0] pixR = '0, pixG = '0, pixB = '0;
  logic       blank = 1'b0;
  logic       ditherOn = 1'b1;
  logic       outR, outG, outB;

  int checks = 0;
  int fails = 0;
  int mLvl[3] = '{0, 0, 0};
  int mSlot = SL;
  bit mDith = 1'b1;
  int hiCnt[3] = '{0, 0, 0};

  always #2.5 clk = ~clk;

  oneBitDither dut_i (
    .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .pixR(pixR), .pixG(pixG),
    .pixB(pixB), .blank(blank), .ditherOn(ditherOn), .outR(outR), .outG(outG),
    .outB(outB)
  );

  function automatic int expLevel(int v, bit dith);
    if (!dith) return (v >= 32) ? SL : 0;
    return $rtoi(v * 8.0 / 63.0 + 0.5);
  endfunction

  function automatic int slotBit(int n, int k);
    return ((k + 1) * n) / SL - (k * n) / SL;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One fast edge: drive inputs, predict outputs after the edge, compare.
  task automatic step(input bit s, input logic [5:0] r, g, b,
                      input bit bl, input bit dith, input string tag);
    logic [2:0] exp;
    logic [2:0] got;
    string t;
    pixStrobe = s; pixR = r; pixG = g; pixB = b; blank = bl; ditherOn = dith;
    if (tag != "") t = tag;
    else if (!rstN) t = "R1";
    else if (bl) t = "R6";
    else if (mSlot >= SL) t = "R5";
    else if (!mDith) t = "R7";
    else t = "R3";
    for (int ch = 0; ch < 3; ch++)
      exp[ch] = (rstN && !bl && mSlot < SL) ? slotBit(mLvl[ch], mSlot) != 0 : 1'b0;
    if (rstN && s) begin
      mLvl[0] = expLevel(r, dith);
      mLvl[1] = expLevel(g, dith);
      mLvl[2] = expLevel(b, dith);
      mDith = dith;
      mSlot = 0;
    end else if (rstN && mSlot < SL) begin
      mSlot++;
    end
    @(posedge clk);
    @(negedge clk);
    got = {outB, outG, outR};
    for (int ch = 0; ch < 3; ch++) hiCnt[ch] += int'(got[ch]);
    check(t, int'(got), int'(exp));
  endtask

  task automatic pixelCount(input logic [5:0] r, g, b, input bit dith);
    step(1'b1, r, g, b, 1'b0, dith, "R4");
    hiCnt = '{0, 0, 0};
    for (int k = 0; k < SL; k++) step(1'b0, '0, '0, '0, 1'b0, dith, "");
    check("R2 R8 red count", hiCnt[0], expLevel(r, dith));
    check("R2 R8 green count", hiCnt[1], expLevel(g, dith));
    check("R2 R8 blue count", hiCnt[2], expLevel(b, dith));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] vals[7] = '{6'd0, 6'd1, 6'd4, 6'd31, 6'd32, 6'd59, 6'd63};
    void'($urandom(32'd4711));
    @(negedge clk);
    // R1: reset and post-reset idle
    for (int i = 0; i < 3; i++) step(1'b0, 6'd63, 6'd63, 6'd63, 1'b0, 1'b1, "R1");
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 6'd63, 6'd63, 6'd63, 1'b0, 1'b1, "R1");

    // R2, R8: rounding boundaries, distinct per channel
    foreach (vals[i]) pixelCount(vals[i], 6'd63 - vals[i], vals[(i + 3) % 7], 1'b1);

    // R7: MSB mode
    pixelCount(6'd31, 6'd32, 6'd63, 1'b0);
    pixelCount(6'd0, 6'd33, 6'd20, 1'b0);

    // R4: early strobe restarts at slot 0
    step(1'b1, 6'd32, 6'd40, 6'd10, 1'b0, 1'b1, "R4");
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, '0, 1'b0, 1'b1, "R4");
    step(1'b1, 6'd63, 6'd8, 6'd50, 1'b0, 1'b1, "R4");
    for (int k = 0; k < SL; k++) step(1'b0, '0, '0, '0, 1'b0, 1'b1, "R4");

    // R6: blank in mid-pixel; R5: late strobe gives idle slots
    step(1'b1, 6'd63, 6'd63, 6'd63, 1'b0, 1'b1, "R4");
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, "R3");
    step(1'b0, '0, '0, '0, 1'b1, 1'b1, "R6");
    step(1'b0, '0, '0, '0, 1'b1, 1'b1, "R6");
    for (int k = 0; k < SL; k++) step(1'b0, '0, '0, '0, 1'b0, 1'b1, "");

    // Random stream
    for (int p = 0; p < 300; p++) begin
      int sel = $urandom % 10;
      int per = (sel == 0) ? 5 : (sel == 1) ? 11 : SL;
      bit dith = ($urandom % 5) != 0;
      step(1'b1, 6'($urandom), 6'($urandom), 6'($urandom),
           ($urandom % 10) == 0, dith, "");
      for (int k = 1; k < per; k++)
        step(1'b0, 6'($urandom), 6'($urandom), 6'($urandom),
             ($urandom % 10) == 0, $urandom % 2 == 0, "");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule